// File: doc/BRIEF.md
# Capture/Compare Timer with Low-Power Handling

This block is a 16-bit free-running timer for a small 8-bit controller. It counts prescaled ticks and has one input-capture channel and one output-compare channel. Software reaches it through an 8-bit register port with eight addresses. A power controller drives three inputs: a wait level, a stop level, and a wake-cause bit that says whether stop ended through an interrupt. In wait the timer keeps running. In stop it freezes its count.

In stop mode a capture edge is not acted on at once. The first valid edge stores the frozen count in a private hold register and arms a pending latch. If stop ends through an interrupt, that value is moved to the capture register and the capture flag rises. If stop ends any other way, including reset, the pending edge is dropped. A write to the compare high byte blocks matching until the low byte is written, so software can change a 16-bit compare value without a false match in the middle of the update.

Register map (address: content): 0 control, 1 status, 2 count high, 3 count low, 4 capture high, 5 capture low, 6 compare high, 7 compare low.

Control bits: bit0 selects a rising capture edge when 1 and a falling edge when 0. Bit1 is the level driven on the compare pin at a match. Bit2 enables the capture interrupt. Bit3 enables the compare interrupt.

Status bits: bit0 is the capture flag and bit1 is the compare flag. Bits 7..2 read as 0.

Top module: `cc_timer`

## Requirements
- R1: After reset the count is 0xFFFC, the control register and both flags are 0, the compare pin is 0, and the compare value is 0xFFFF with matching inhibited.
- R2: The count rises by one on every clock with tick_i high and stop_i low. It wraps from 0xFFFF to 0x0000.
- R3: wait_i has no effect: the count, the flags and the interrupt behave the same with it high.
- R4: While stop_i is high the count holds its value and no compare match can occur. Counting resumes from the held value after stop ends.
- R5: Outside stop, a capture-pin edge of the polarity chosen by control bit0 copies the count into the capture register and sets status bit0. An edge of the other polarity is ignored.
- R6: During stop, capture edges set no flag and raise no interrupt. Only the first edge in a stop period is kept.
- R7: When stop falls with stop_wake_irq_i high and an edge is pending, status bit0 is set and the capture register holds the count taken at the first stop edge.
- R8: When stop ends with stop_wake_irq_i low, or through reset, the pending edge is dropped: no flag is set and no captured data is kept.
- R9: A write to address 6 inhibits matching. A later write to address 7 enables it again.
- R10: When matching is enabled and the count steps onto the compare value, status bit1 is set and the compare pin takes control bit1. Both change in the cycle the count arrives.
- R11: Status bit1 is cleared by a read of address 1 while it is set, followed by a write to address 7. Status bit0 is cleared by a read of address 1 while it is set, followed by a read of address 5.
- R12: irq_o is high exactly when status bit0 and control bit2 are both set, or status bit1 and control bit3 are both set.
- R13: A read of address 2 or 4 latches the matching low byte. The next read of address 3 or 5 returns that latched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| wait_i | input | 1 | Wait mode level from the power controller |
| stop_i | input | 1 | Stop mode level from the power controller |
| stop_wake_irq_i | input | 1 | High when stop is being left through an interrupt |
| cap_pin_i | input | 1 | Capture pin |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe; side effects occur on the clock edge |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i; combinational |
| cmp_pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded assertions check four things on every clock. The count steps by exactly one when enabled. It is held in stop. The capture flag never rises while stop is sampled high. The compare flag never rises from a cycle in which matching was inhibited. Other behaviours only show up across a chain of accesses, so only the bench scenarios can show them. These are the two-step flag-clearing sequences, the high-then-low byte latching, keeping versus discarding a stop-period edge depending on the wake cause or a reset, and the capture and compare values themselves.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [2:0] {
      A_CTRL = 3'd0,
      A_STAT = 3'd1,
      A_CNTH = 3'd2,
      A_CNTL = 3'd3,
      A_CAPH = 3'd4,
      A_CAPL = 3'd5,
      A_CMPH = 3'd6,
      A_CMPL = 3'd7
   } tmr_addr_e;

   typedef struct packed {
      logic cmp_ie;
      logic cap_ie;
      logic cmp_lvl;
      logic cap_rise;
   } tmr_ctrl_t;

   localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned W   = 16,
   parameter logic [W-1:0] RST = 16'hFFFC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         stop_i,
   output logic [W-1:0] cnt_o,
   output logic         step_o
);
   assign step_o = tick_i & ~stop_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= RST;
      else if (step_o) cnt_o <= cnt_o + 1'b1;
   end

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && !stop_i |=> cnt_o == $past(cnt_o) + 1'b1);

   assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
   parameter int unsigned W        = 16,
   parameter int unsigned CAP_SYNC = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pin_i,
   input  logic         rise_i,
   input  logic         stop_i,
   input  logic         wake_irq_i,
   input  logic [W-1:0] cnt_i,
   input  logic         stat_rd_i,
   input  logic         lo_rd_i,
   output logic [W-1:0] cap_o,
   output logic         flag_o
);
   logic         pin_s, pin_q, hit;
   logic [W-1:0] hold_q;
   logic         pend_q, stop_q, arm_q, leave_ok;

   generate
      if (CAP_SYNC == 1) begin : g_sync
         logic sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 1'b0;
            else        sync_q <= pin_i;
         end
         assign pin_s = sync_q;
      end else begin : g_direct
         assign pin_s = pin_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q  <= 1'b0;
         stop_q <= 1'b0;
      end else begin
         pin_q  <= pin_s;
         stop_q <= stop_i;
      end
   end

   assign hit      = rise_i ? (pin_s & ~pin_q) : (~pin_s & pin_q);
   assign leave_ok = stop_q & ~stop_i & pend_q & wake_irq_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         hold_q <= '0;
      end else if (stop_i) begin
         if (hit && !pend_q) begin
            pend_q <= 1'b1;
            hold_q <= cnt_i;
         end
      end else begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_o  <= '0;
         flag_o <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (lo_rd_i && arm_q)          arm_q <= 1'b0;
         else if (stat_rd_i && flag_o)  arm_q <= 1'b1;
         if (leave_ok) begin
            cap_o  <= hold_q;
            flag_o <= 1'b1;
         end else if (hit && !stop_i) begin
            cap_o  <= cnt_i;
            flag_o <= 1'b1;
         end else if (lo_rd_i && arm_q) begin
            flag_o <= 1'b0;
         end
      end
   end

   assert_no_flag_in_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i && !flag_o |=> !flag_o);

   assert_first_edge_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && stop_i |=> $stable(hold_q));

   assert_flag_rise_outside_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> !$past(stop_i));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
   parameter int unsigned W  = 16,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_i,
   input  logic [W-1:0]  cnt_i,
   input  logic          lvl_i,
   input  logic          wr_hi_i,
   input  logic          wr_lo_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          stat_rd_i,
   output logic [W-1:0]  cmp_o,
   output logic          flag_o,
   output logic          pin_o
);
   logic inh_q, arm_q, match;
   logic [W-1:0] cnt_next;

   assign cnt_next = cnt_i + 1'b1;
   assign match    = step_i & ~inh_q & (cnt_next == cmp_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_o <= '1;
         inh_q <= 1'b1;
      end else if (wr_hi_i) begin
         cmp_o[W-1:DW] <= wdata_i;
         inh_q         <= 1'b1;
      end else if (wr_lo_i) begin
         cmp_o[DW-1:0] <= wdata_i;
         inh_q         <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         arm_q  <= 1'b0;
         pin_o  <= 1'b0;
      end else begin
         if (wr_lo_i && arm_q)          arm_q <= 1'b0;
         else if (stat_rd_i && flag_o)  arm_q <= 1'b1;
         if (match) begin
            flag_o <= 1'b1;
            pin_o  <= lvl_i;
         end else if (wr_lo_i && arm_q) begin
            flag_o <= 1'b0;
         end
      end
   end

   assert_no_match_inhibited_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> !$past(inh_q));

   assert_match_needs_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(step_i));
endmodule

// File: rtl/cc_timer.sv
module cc_timer
   import tmr_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RST_VALUE = 'hFFFC,
   parameter int unsigned CAP_SYNC  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wait_i,
   input  logic              stop_i,
   input  logic              stop_wake_irq_i,
   input  logic              cap_pin_i,
   input  logic [2:0]        addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              cmp_pin_o,
   output logic              irq_o
);
   localparam int unsigned CNT_W = 2 * DATA_W;

   generate
      if (DATA_W < CTRL_W) begin : g_bad_width
         $error("DATA_W must hold the control register");
      end
      if (CAP_SYNC > 1) begin : g_bad_sync
         $error("CAP_SYNC must be 0 or 1");
      end
   endgenerate

   tmr_addr_e          a;
   tmr_ctrl_t          ctrl_q;
   logic [CNT_W-1:0]   cnt, cap, cmp;
   logic               step, cap_flag, cmp_flag, stat_rd;
   logic [DATA_W-1:0]  cnt_buf, cap_buf;
   logic               cnt_bv, cap_bv;

   assign a       = tmr_addr_e'(addr_i);
   assign stat_rd = rd_i && (a == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         cnt_buf <= '0;
         cap_buf <= '0;
         cnt_bv  <= 1'b0;
         cap_bv  <= 1'b0;
      end else begin
         if (wr_i && a == A_CTRL) ctrl_q <= tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
         if (rd_i) begin
            case (a)
               A_CNTH: begin cnt_buf <= cnt[DATA_W-1:0]; cnt_bv <= 1'b1; end
               A_CNTL: cnt_bv <= 1'b0;
               A_CAPH: begin cap_buf <= cap[DATA_W-1:0]; cap_bv <= 1'b1; end
               A_CAPL: cap_bv <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   tmr_counter #(.W(CNT_W), .RST(CNT_W'(RST_VALUE))) i_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .stop_i(stop_i),
      .cnt_o(cnt), .step_o(step));

   tmr_capture #(.W(CNT_W), .CAP_SYNC(CAP_SYNC)) i_cap (
      .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i), .rise_i(ctrl_q.cap_rise),
      .stop_i(stop_i), .wake_irq_i(stop_wake_irq_i), .cnt_i(cnt),
      .stat_rd_i(stat_rd), .lo_rd_i(rd_i && a == A_CAPL),
      .cap_o(cap), .flag_o(cap_flag));

   tmr_compare #(.W(CNT_W), .DW(DATA_W)) i_cmp (
      .clk(clk), .rst_n(rst_n), .step_i(step), .cnt_i(cnt), .lvl_i(ctrl_q.cmp_lvl),
      .wr_hi_i(wr_i && a == A_CMPH), .wr_lo_i(wr_i && a == A_CMPL),
      .wdata_i(wdata_i), .stat_rd_i(stat_rd),
      .cmp_o(cmp), .flag_o(cmp_flag), .pin_o(cmp_pin_o));

   always_comb begin
      case (a)
         A_CTRL:  rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
         A_STAT:  rdata_o = {{(DATA_W-2){1'b0}}, cmp_flag, cap_flag};
         A_CNTH:  rdata_o = cnt[CNT_W-1:DATA_W];
         A_CNTL:  rdata_o = cnt_bv ? cnt_buf : cnt[DATA_W-1:0];
         A_CAPH:  rdata_o = cap[CNT_W-1:DATA_W];
         A_CAPL:  rdata_o = cap_bv ? cap_buf : cap[DATA_W-1:0];
         A_CMPH:  rdata_o = cmp[CNT_W-1:DATA_W];
         default: rdata_o = cmp[DATA_W-1:0];
      endcase
   end

   assign irq_o = (cap_flag & ctrl_q.cap_ie) | (cmp_flag & ctrl_q.cmp_ie);

   assert_wait_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wait_i && tick_i && !stop_i |=> cnt == $past(cnt) + 1'b1);

   assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> cap_flag || cmp_flag);
endmodule

// File: tb/test_cc_timer.sv
module test_cc_timer;
   logic clk = 1'b0, rst_n = 1'b0;
   logic tick = 0, wt = 0, stp = 0, wake = 0, pin = 0, wr = 0, rd = 0;
   logic [2:0] addr = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata;
   logic cpin, irq;
   int checks = 0, errors = 0;
   string phase = "R1";

   always #5 clk = ~clk;

   cc_timer i_cc_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wait_i(wt), .stop_i(stp),
      .stop_wake_irq_i(wake), .cap_pin_i(pin), .addr_i(addr), .wr_i(wr),
      .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .cmp_pin_o(cpin), .irq_o(irq));

   // behavioural reference model
   logic [15:0] m_cnt, m_cap, m_hold, m_cmp;
   logic [3:0]  m_ctrl;
   logic [7:0]  m_cbuf, m_kbuf;
   logic m_icf, m_ocf, m_ai, m_ao, m_pend, m_stopq, m_pinq, m_inh, m_cpin, m_cbv, m_kbv;

   task automatic m_reset();
      m_cnt = 16'hFFFC; m_cap = 0; m_hold = 0; m_cmp = 16'hFFFF; m_ctrl = 0;
      m_cbuf = 0; m_kbuf = 0; m_icf = 0; m_ocf = 0; m_ai = 0; m_ao = 0;
      m_pend = 0; m_stopq = 0; m_pinq = 0; m_inh = 1; m_cpin = 0; m_cbv = 0; m_kbv = 0;
   endtask

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         automatic logic stepv = tick && !stp;
         automatic logic edgev = m_ctrl[0] ? (pin && !m_pinq) : (!pin && m_pinq);
         automatic logic match = stepv && !m_inh && (m_cnt + 16'd1 == m_cmp);
         automatic logic keep  = m_stopq && !stp && m_pend && wake;
         automatic logic clr_o = wr && addr == 7 && m_ao;
         automatic logic clr_i = rd && addr == 5 && m_ai;
         automatic logic arm_o = rd && addr == 1 && m_ocf;
         automatic logic arm_i = rd && addr == 1 && m_icf;
         automatic logic [15:0] c0 = m_cnt;
         if (clr_o) m_ao = 0; else if (arm_o) m_ao = 1;
         if (clr_i) m_ai = 0; else if (arm_i) m_ai = 1;
         if (match) begin m_ocf = 1; m_cpin = m_ctrl[1]; end
         else if (clr_o) m_ocf = 0;
         if (keep) begin m_cap = m_hold; m_icf = 1; end
         else if (edgev && !stp) begin m_cap = c0; m_icf = 1; end
         else if (clr_i) m_icf = 0;
         if (stp) begin
            if (edgev && !m_pend) begin m_pend = 1; m_hold = c0; end
         end else m_pend = 0;
         if (wr && addr == 6) begin m_cmp[15:8] = wdata; m_inh = 1; end
         else if (wr && addr == 7) begin m_cmp[7:0] = wdata; m_inh = 0; end
         if (wr && addr == 0) m_ctrl = wdata[3:0];
         if (rd) begin
            if (addr == 2) begin m_cbuf = c0[7:0]; m_cbv = 1; end
            if (addr == 3) m_cbv = 0;
            if (addr == 4) begin m_kbuf = m_cap[7:0]; m_kbv = 1; end
            if (addr == 5) m_kbv = 0;
         end
         if (stepv) m_cnt = c0 + 16'd1;
         m_stopq = stp; m_pinq = pin;
      end
   end

   function automatic logic [7:0] m_rd(input logic [2:0] a);
      case (a)
         3'd0: return {4'b0, m_ctrl};
         3'd1: return {6'b0, m_ocf, m_icf};
         3'd2: return m_cnt[15:8];
         3'd3: return m_cbv ? m_cbuf : m_cnt[7:0];
         3'd4: return m_cap[15:8];
         3'd5: return m_kbv ? m_kbuf : m_cap[7:0];
         3'd6: return m_cmp[15:8];
         default: return m_cmp[7:0];
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk({phase, " rdata"}, {8'h0, rdata}, {8'h0, m_rd(addr)});
         chk({phase, " irq R12"}, {15'h0, irq}, {15'h0, (m_icf & m_ctrl[2]) | (m_ocf & m_ctrl[3])});
         chk({phase, " cmp pin R10"}, {15'h0, cpin}, {15'h0, m_cpin});
      end
   end

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) begin @(posedge clk); #2; end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1; cyc(1); wr = 0;
   endtask

   task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
      addr = a; rd = 1; #1;
      chk(tag, {8'h0, rdata}, {8'h0, e});
      cyc(1); rd = 0;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      cyc(3); rst_n = 1; cyc(1);
      phase = "R1";
      rd_exp(2, 8'hFF, "R1 count high"); rd_exp(3, 8'hFC, "R1 count low");
      rd_exp(1, 8'h00, "R1 status");     rd_exp(0, 8'h00, "R1 control");
      rd_exp(6, 8'hFF, "R1 compare high");
      reg_wr(0, 8'h0F);
      phase = "R2"; tick = 1; cyc(6); tick = 0;
      rd_exp(2, 8'h00, "R2 wrap high");
      phase = "R13"; tick = 1; cyc(1); tick = 0;
      rd_exp(3, 8'h02, "R13 latched low");
      rd_exp(3, 8'h03, "R13 live low");
      phase = "R3"; wt = 1; tick = 1; cyc(4); tick = 0; wt = 0;
      rd_exp(3, 8'h07, "R3 counting in wait");
      phase = "R5"; pin = 1; cyc(1);
      rd_exp(1, 8'h01, "R5 rising capture flag");
      rd_exp(4, 8'h00, "R5 capture high");
      rd_exp(5, 8'h07, "R5 capture low");
      phase = "R11"; rd_exp(1, 8'h00, "R11 capture flag cleared");
      phase = "R5"; reg_wr(0, 8'h0E); tick = 1; cyc(3); tick = 0;
      pin = 0; cyc(1);
      rd_exp(1, 8'h01, "R5 falling capture flag");
      rd_exp(5, 8'h0A, "R5 falling capture value");
      pin = 1; cyc(2);
      rd_exp(1, 8'h00, "R5 wrong polarity ignored");
      phase = "R9"; reg_wr(6, 8'h00); reg_wr(7, 8'h0E); reg_wr(6, 8'h00);
      tick = 1; cyc(6); tick = 0;
      rd_exp(1, 8'h00, "R9 inhibited pass");
      reg_wr(7, 8'h14);
      phase = "R10"; tick = 1; cyc(4); tick = 0;
      chk("R10 pin level", {15'h0, cpin}, 16'h1);
      rd_exp(1, 8'h02, "R10 compare flag");
      phase = "R12"; chk("R12 irq on", {15'h0, irq}, 16'h1);
      reg_wr(0, 8'h06); #1;
      chk("R12 irq masked", {15'h0, irq}, 16'h0);
      reg_wr(0, 8'h0E);
      phase = "R11"; reg_wr(7, 8'h40);
      rd_exp(1, 8'h00, "R11 compare flag cleared");
      phase = "R4"; stp = 1; tick = 1; cyc(2);
      phase = "R6"; pin = 0; cyc(1); pin = 1; cyc(1); pin = 0; cyc(1);
      chk("R6 no irq in stop", {15'h0, irq}, 16'h0);
      rd_exp(1, 8'h00, "R6 no flag in stop");
      rd_exp(3, 8'h14, "R4 frozen count");
      tick = 0;
      phase = "R7"; stp = 0; wake = 1; cyc(1); wake = 0;
      rd_exp(1, 8'h01, "R7 flag after wake");
      rd_exp(5, 8'h14, "R7 first edge value");
      phase = "R4"; tick = 1; cyc(2); tick = 0;
      rd_exp(3, 8'h16, "R4 resumed count");
      phase = "R8"; stp = 1; pin = 1; cyc(1); pin = 0; cyc(1);
      stp = 0; cyc(1);
      rd_exp(1, 8'h00, "R8 dropped without wake");
      rd_exp(5, 8'h14, "R8 capture unchanged");
      stp = 1; pin = 1; cyc(1); pin = 0; cyc(1);
      rst_n = 0; cyc(2); stp = 0; rst_n = 1; cyc(1);
      rd_exp(1, 8'h00, "R8 dropped by reset");
      rd_exp(5, 8'h00, "R8 no data after reset");
      phase = "R1"; rd_exp(3, 8'hFC, "R1 count after reset");
      cyc(2);
      finish_run();
   end
endmodule